// File: doc/BRIEF.md
# Zero-Register Dual-Read Register File

This block is the general-purpose register store of a small integer datapath. It holds thirty-two words of thirty-two bits. Two read ports each take a five-bit index and return the selected word combinationally, so an operand fetch never costs a clock. A single write port takes an index, a data word and an enable. It commits on the falling clock edge, so a result written in the first half of a cycle can be read back in the second half of the same cycle.

Entry zero is a constant: it reads as zero on every port and ignores every write, which gives the instruction stream a free zero source and a discard target. A synchronous active-high reset clears the other entries. A third index selects a word onto a debug output, so the contents can be observed without using either operand port.

Top module: `zeroRegFile`

## Requirements
- R1: The store has 32 entries of 32 bits, selected by 5-bit indices; each of entries 1 to 31 reads back exactly the last word written to it.
- R2: Index 0 reads as 32'h0 on every read port, and a write aimed at index 0 leaves that reading unchanged.
- R3: A write commits only when the write enable is 1 at a falling clock edge; with the enable at 0 the contents stay the same.
- R4: A write is not visible before its falling edge; after that edge the new word appears on the read ports without waiting for another edge.
- R5: Reset is active high and synchronous to the falling edge; it clears entries 1 to 31 to zero and overrides a write presented at the same edge.
- R6: The two operand read ports are independent; when they select the same index they return the same word.
- R7: A debug read port with its own 5-bit index returns the selected entry of the same store, combinationally, with index 0 reading as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high clear of entries 1 to 31 |
| rdIdxA | input | 5 | Index for operand read port A |
| rdDataA | output | 32 | Word selected by rdIdxA |
| rdIdxB | input | 5 | Index for operand read port B |
| rdDataB | output | 32 | Word selected by rdIdxB |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Index of the entry to write |
| wrData | input | 32 | Word to write |
| dbgIdx | input | 5 | Index for the debug read port |
| dbgData | output | 32 | Word selected by dbgIdx |

## Verification
Every index is written with a word derived arithmetically from the index, so a decode that lands a write in the wrong row or returns a neighbouring row shows up as a mismatch against the formula, and every pairing of the two operand indices is swept to tell the ports apart. Writes to index 0 and writes with the enable low are tried with distinctive words to show they change nothing. A write is probed both between the rising and falling edge and just after the falling edge, separating a falling-edge commit from a rising-edge or level-sensitive one. Reset is asserted together with a write to confirm the clear wins.

// File: rtl/zrfPkg.sv
package zrfPkg;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);

  typedef struct packed {
    logic clearAll;
    logic commit;
  } rfStrobe_t;
endpackage

// File: rtl/zrfCtrl.sv
module zrfCtrl
  import zrfPkg::*;
#(
  parameter int unsigned REG_COUNT = zrfPkg::REG_COUNT,
  localparam int unsigned IDX_W = $clog2(REG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  output rfStrobe_t            strobes,
  output logic [REG_COUNT-1:0] rowSel
);
  // Reset overrides any write; index 0 never commits.
  assign strobes.clearAll = rst;
  assign strobes.commit   = wrEn && !rst && (wrIdx != '0);

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
    if (i == 0) begin : g_zero
      assign rowSel[i] = 1'b0;
    end else begin : g_row
      assign rowSel[i] = strobes.commit && (wrIdx == IDX_W'(i));
    end
  end

  // R3: at most one row selected, and only when enabled
  p_single_row_r3: assert property (@(negedge clk) disable iff (rst)
    $onehot0(rowSel) && (!wrEn -> rowSel == '0));
  // R2: index 0 request never reaches a row
  p_zero_no_select_r2: assert property (@(negedge clk) disable iff (rst)
    (wrIdx == '0) |-> (rowSel == '0));
endmodule

// File: rtl/zrfDatapath.sv
module zrfDatapath
  import zrfPkg::*;
#(
  parameter int unsigned REG_COUNT = zrfPkg::REG_COUNT,
  parameter int unsigned DATA_W    = zrfPkg::DATA_W
) (
  input  logic                               clk,
  input  rfStrobe_t                          strobes,
  input  logic [REG_COUNT-1:0]               rowSel,
  input  logic [DATA_W-1:0]                  wrData,
  output logic [REG_COUNT-1:0][DATA_W-1:0]   store
);
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_rows
    if (i == 0) begin : g_const
      assign store[i] = '0;
      // R2: the constant row is never targeted
      p_row0_idle_r2: assert property (@(negedge clk)
        disable iff (strobes.clearAll) !rowSel[i]);
    end else begin : g_reg
      logic [DATA_W-1:0] rowQ;
      always_ff @(negedge clk) begin
        if (strobes.clearAll)  rowQ <= '0;
        else if (rowSel[i])    rowQ <= wrData;
      end
      assign store[i] = rowQ;

      // R1: a selected row takes the presented word
      p_row_write_r1: assert property (@(negedge clk)
        disable iff (strobes.clearAll)
        rowSel[i] |=> (store[i] == $past(wrData)));
      // R3: an unselected row holds its value
      p_row_hold_r3: assert property (@(negedge clk)
        disable iff (strobes.clearAll)
        !rowSel[i] |=> $stable(store[i]));
      // R5: the edge after a reset edge sees a cleared row
      p_row_clear_r5: assert property (@(negedge clk)
        disable iff (strobes.clearAll)
        $past(strobes.clearAll) |-> (store[i] == '0));
    end
  end
endmodule

// File: rtl/zrfReadPort.sv
module zrfReadPort #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W = $clog2(REG_COUNT)
) (
  input  logic [IDX_W-1:0]                 idx,
  input  logic [REG_COUNT-1:0][DATA_W-1:0] store,
  output logic [DATA_W-1:0]                data
);
  assign data = (idx == '0) ? '0 : store[idx];
endmodule

// File: rtl/zeroRegFile.sv
module zeroRegFile
  import zrfPkg::*;
#(
  parameter int unsigned REG_COUNT = zrfPkg::REG_COUNT,
  parameter int unsigned DATA_W    = zrfPkg::DATA_W,
  localparam int unsigned IDX_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  rfStrobe_t                        strobes;
  logic [REG_COUNT-1:0]             rowSel;
  logic [REG_COUNT-1:0][DATA_W-1:0] store;

  zrfCtrl #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx),
    .strobes(strobes), .rowSel(rowSel)
  );

  zrfDatapath #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .strobes(strobes), .rowSel(rowSel),
    .wrData(wrData), .store(store)
  );

  zrfReadPort #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_rdA (
    .idx(rdIdxA), .store(store), .data(rdDataA));
  zrfReadPort #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_rdB (
    .idx(rdIdxB), .store(store), .data(rdDataB));
  zrfReadPort #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_rdDbg (
    .idx(dbgIdx), .store(store), .data(dbgData));

  // R6: same index on both operand ports gives the same word
  p_same_index_r6: assert property (@(posedge clk) disable iff (rst)
    (rdIdxA == rdIdxB) |-> (rdDataA == rdDataB));
  // R2: zero index reads zero on every port
  p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
    ((rdIdxA == '0) -> (rdDataA == '0)) && ((rdIdxB == '0) -> (rdDataB == '0))
    && ((dbgIdx == '0) -> (dbgData == '0)));
  // R7: debug port agrees with port A on a shared index
  p_dbg_match_r7: assert property (@(posedge clk) disable iff (rst)
    (dbgIdx == rdIdxA) |-> (dbgData == rdDataA));
endmodule

// File: tb/zeroRegFile_bench.sv
module zeroRegFile_bench;
  localparam int PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0, dbgIdx = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB, dbgData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  zeroRegFile u_zeroRegFile (
    .clk(clk), .rst(rst), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'h9E37_79B9 * 32'(i + 1)) ^ salt;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a write after a rising edge; it commits at the next falling edge.
  task automatic doWrite(input logic en, input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = en; wrIdx = 5'(idx); wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readAll(input int idx, output logic [31:0] a,
                         output logic [31:0] b, output logic [31:0] g);
    rdIdxA = 5'(idx); rdIdxB = 5'(idx); dbgIdx = 5'(idx); #1;
    a = rdDataA; b = rdDataB; g = dbgData;
  endtask

  logic [31:0] model [N];

  initial begin
    logic [31:0] a, b, g;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R5: reset state
    for (int i = 0; i < N; i++) begin
      readAll(i, a, b, g);
      check("R5 reset", a, 32'h0);
      model[i] = 32'h0;
    end
    // R1: fill every index
    for (int i = 0; i < N; i++) begin
      doWrite(1'b1, i, pat(i, 32'h5A5A_0000));
      if (i != 0) model[i] = pat(i, 32'h5A5A_0000);
    end
    for (int i = 0; i < N; i++) begin
      readAll(i, a, b, g);
      check(i == 0 ? "R2 zero A" : "R1 port A", a, model[i]);
      check("R6 port B", b, model[i]);
      check("R7 debug", g, model[i]);
    end
    // R6: every pairing of the two operand indices
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        rdIdxA = 5'(x); rdIdxB = 5'(y); #1;
        check("R6 pair A", rdDataA, model[x]);
        check("R6 pair B", rdDataB, model[y]);
      end
    end
    // R2: write to index 0 ignored
    doWrite(1'b1, 0, 32'hFFFF_FFFF);
    readAll(0, a, b, g);
    check("R2 write zero", a, 32'h0);
    check("R2 write zero dbg", g, 32'h0);
    // R3: enable low changes nothing
    for (int i = 1; i < N; i += 5) begin
      doWrite(1'b0, i, ~model[i]);
      readAll(i, a, b, g);
      check("R3 enable low", a, model[i]);
    end
    // R4: not visible between rising and falling edge; visible right after
    rdIdxA = 5'd9; rdIdxB = 5'd9;
    @(posedge clk); #1;
    wrEn = 1'b1; wrIdx = 5'd9; wrData = 32'hCAFE_0009;
    #2 check("R4 before fall", rdDataA, model[9]);
    @(negedge clk); #1;
    wrEn = 1'b0;
    model[9] = 32'hCAFE_0009;
    check("R4 after fall", rdDataA, model[9]);
    check("R4 after fall B", rdDataB, model[9]);
    // R1: overwrite and neighbours untouched
    doWrite(1'b1, 31, 32'h8000_0001);
    model[31] = 32'h8000_0001;
    readAll(31, a, b, g);
    check("R1 overwrite", a, model[31]);
    readAll(30, a, b, g);
    check("R1 neighbour", a, model[30]);
    // R5: reset with simultaneous write; reset wins
    @(posedge clk); #1;
    rst = 1'b1; wrEn = 1'b1; wrIdx = 5'd12; wrData = 32'h1234_5678;
    @(negedge clk); #1;
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < N; i++) begin
      readAll(i, a, b, g);
      check("R5 clear", a, 32'h0);
      check("R5 clear dbg", g, 32'h0);
    end
    // R3: usable again after reset
    doWrite(1'b1, 12, 32'h0BAD_F00D);
    readAll(12, a, b, g);
    check("R3 post reset", a, 32'h0BAD_F00D);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule